// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port that sits beside a memory macro. A four-wire serial interface with a mode line, a data-in line, a test clock and a data-out line steps a sixteen-state controller. Through that interface the tester loads a three-bit instruction, then moves one data register at a time through a serial shift path. The data registers are a one-bit bypass cell, a thirty-two-bit identification word and a short boundary register of configurable length. The boundary register captures a parallel input vector and presents its last loaded contents on a parallel hold output.

Every input is taken on the rising test-clock edge. Serial data enters at the most significant end of the selected register and leaves from its least significant end. The data-out line is re-timed to the falling edge, and its drive enable is raised only while a shift state is active. A synchronous active-low reset and a run of five mode-high clocks both return the port to its reset state. In that state the identification instruction is active.

Top module: `tap_port`

## Requirements
- R1: With `rst_n` low at a rising `tck` edge the controller enters Test-Logic-Reset. From the next falling edge the active instruction is IDCODE and `tdo_en` is 0. This holds even when reset strikes in the middle of a shift.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, which makes IDCODE the active instruction.
- R3: The controller follows the standard sixteen-state diagram, including the Exit1, Pause and Exit2 detour that suspends a shift and then resumes it without losing bits.
- R4: Under IDCODE (code 001), Capture-DR loads `ID_VALUE` with bit 0 forced to 1, and the word leaves on `tdo` least significant bit first.
- R5: Under BYPASS (code 111), Capture-DR loads 0 into the one-bit register, so `tdo` repeats `tdi` one shift later.
- R6: The unused codes 011, 101 and 110 behave exactly like BYPASS.
- R7: Capture-IR loads 001 into the three-bit instruction shift stage. The shifted value becomes the active instruction only on the falling edge inside Update-IR.
- R8: In every shift the bit on `tdi` enters at the most significant end of the selected register and `tdo` carries its least significant bit. Instruction bit 0 is the first bit shifted.
- R9: `tdo` and `tdo_en` change only on falling `tck` edges and never at a rising edge.
- R10: `tdo_en` is 1 only during Shift-IR and Shift-DR and is 0 in every other state.
- R11: Under EXTEST (000), SAMPLE-Z (010) and SAMPLE/PRELOAD (100) the boundary register sits in the path, and Capture-DR loads it from `bsr_pins`.
- R12: `bsr_hold` takes the boundary shift contents on the falling edge in Update-DR, and only when a boundary instruction is active. Update-DR under any other instruction leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising `tck` |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| bsr_pins | input | BSR_LEN | Parallel values captured into the boundary register |
| tdo | output | 1 | Serial data out, valid when `tdo_en` is 1 |
| tdo_en | output | 1 | Drive enable for `tdo`; 0 means high impedance |
| bsr_hold | output | BSR_LEN | Boundary contents latched at Update-DR |

## Verification
The bench overrides the parameters with a six-bit boundary register and an identification value whose bit 0 is 0. The short boundary length lets full capture, shift and update cycles run for all three boundary instructions within a few dozen clocks. The even identification value makes the forced bit 0 visible as a difference on the first bit out. The full thirty-two-bit word is read back after power-up reset, after a mode-line reset and after a reset in the middle of a shift.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
// tap_pkg: shared types for the test access port.
// Holds the controller state encoding, the instruction codes and the
// decode from an instruction to the data register it places in the path.
package tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PA_DR   = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PA_IR   = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_e;

    localparam logic [IR_W-1:0] INS_EXTEST     = 3'b000;
    localparam logic [IR_W-1:0] INS_IDCODE     = 3'b001;
    localparam logic [IR_W-1:0] INS_SAMPLE_Z   = 3'b010;
    localparam logic [IR_W-1:0] INS_SAMPLE_PRE = 3'b100;
    localparam logic [IR_W-1:0] INS_BYPASS     = 3'b111;

    // Fixed value loaded into the instruction shift stage at Capture-IR.
    localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 3'b001;

    typedef enum logic [1:0] {
        DR_BYPASS   = 2'd0,
        DR_IDENT    = 2'd1,
        DR_BOUNDARY = 2'd2
    } dr_sel_e;

    // Maps an instruction to its data register; unlisted codes bypass.
    function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] ins);
        dr_sel_e sel;
        case (ins)
            INS_IDCODE:     sel = DR_IDENT;
            INS_EXTEST,
            INS_SAMPLE_Z,
            INS_SAMPLE_PRE: sel = DR_BOUNDARY;
            default:        sel = DR_BYPASS;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
// tap_fsm: the sixteen-state test controller.
// Steps on each rising tck edge according to tms. Assumes rst_n is
// synchronous to tck; reset and five tms-high edges both reach ST_RESET.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state choice for every state of the diagram.
    always_comb begin
        case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    AST_RESET_TO_TLR: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(rst_n) |-> state == ST_RESET); // R1

    AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!rst_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> state == ST_RESET); // R2

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
// tap_ir: instruction shift stage and active instruction.
// The shift stage captures and shifts on rising tck; the active copy is
// loaded on falling tck, with IDCODE in reset and the shifted value in
// Update-IR. Assumes the controller state is registered on rising tck.
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_active,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    // Shift stage: fixed capture pattern, MSB-in shifting.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            ir_sr <= IR_CAPTURE_VAL;
        end else begin
            case (state)
                ST_CAP_IR: ir_sr <= IR_CAPTURE_VAL;
                ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                default:   ir_sr <= ir_sr;
            endcase
        end
    end

    // Active instruction: reset value or update, on the falling edge.
    always_ff @(negedge tck) begin
        if (state == ST_RESET)       ir_active <= INS_IDCODE;
        else if (state == ST_UPD_IR) ir_active <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    AST_IR_IDCODE_IN_RESET: assert property (@(posedge tck) disable iff (!rst_n)
        state == ST_RESET |-> ir_active == INS_IDCODE); // R1

    AST_IR_HOLDS_OUTSIDE_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_RESET) |-> $stable(ir_active)); // R7

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
// tap_dr: the data registers (bypass, identification, boundary stub).
// Only the register chosen by dr_sel captures or shifts. The boundary hold
// stage loads on falling tck in Update-DR under a boundary instruction.
// Assumes dr_sel is stable across the rising edges of a capture/shift.
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h1234_5679
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    input  tap_state_e         state,
    input  dr_sel_e            dr_sel,
    input  logic [BSR_LEN-1:0] bsr_pins,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] bsr_hold
);

    localparam logic [ID_W-1:0] ID_CAPTURE = {ID_VALUE[ID_W-1:1], 1'b1};

    logic               byp_q;
    logic [ID_W-1:0]    id_sr;
    logic [BSR_LEN-1:0] bsr_sr;

    logic cap_en, sh_en;
    assign cap_en = (state == ST_CAP_DR);
    assign sh_en  = (state == ST_SH_DR);

    // Bypass cell: clears on capture, passes tdi when shifting.
    always_ff @(posedge tck) begin
        if (!rst_n)                                 byp_q <= 1'b0;
        else if (dr_sel == DR_BYPASS && cap_en)     byp_q <= 1'b0;
        else if (dr_sel == DR_BYPASS && sh_en)      byp_q <= tdi;
    end

    // Identification register: loads the ID word, shifts MSB-in.
    always_ff @(posedge tck) begin
        if (!rst_n)                                 id_sr <= ID_CAPTURE;
        else if (dr_sel == DR_IDENT && cap_en)      id_sr <= ID_CAPTURE;
        else if (dr_sel == DR_IDENT && sh_en)       id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Boundary shift stage; the single-cell case has no slice to shift.
    generate
        if (BSR_LEN == 1) begin : g_bsr_one
            // One-cell boundary register.
            always_ff @(posedge tck) begin
                if (!rst_n)                              bsr_sr <= '0;
                else if (dr_sel == DR_BOUNDARY && cap_en) bsr_sr <= bsr_pins;
                else if (dr_sel == DR_BOUNDARY && sh_en)  bsr_sr <= tdi;
            end
        end else begin : g_bsr_wide
            // Multi-cell boundary register, MSB-in shifting.
            always_ff @(posedge tck) begin
                if (!rst_n)                              bsr_sr <= '0;
                else if (dr_sel == DR_BOUNDARY && cap_en) bsr_sr <= bsr_pins;
                else if (dr_sel == DR_BOUNDARY && sh_en)  bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
            end
        end
    endgenerate

    // Boundary hold stage, updated on the falling edge in Update-DR.
    always_ff @(negedge tck) begin
        if (!rst_n)                                          bsr_hold <= '0;
        else if (state == ST_UPD_DR && dr_sel == DR_BOUNDARY) bsr_hold <= bsr_sr;
    end

    // Serial output of the selected register.
    always_comb begin
        case (dr_sel)
            DR_IDENT:    dr_lsb = id_sr[0];
            DR_BOUNDARY: dr_lsb = bsr_sr[0];
            default:     dr_lsb = byp_q;
        endcase
    end

    AST_ID_LSB_SET: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_en && dr_sel == DR_IDENT) |=> id_sr[0]); // R4

    AST_HOLD_ONLY_AT_UPDATE: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_DR && $past(rst_n)) |-> $stable(bsr_hold)); // R12

endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
// tap_port: top of the test access port.
// Connects controller, instruction and data registers, selects the serial
// source and re-times tdo and its enable onto falling tck. Assumes all
// inputs are synchronous to tck and rst_n is active low.
module tap_port
    import tap_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h1234_5679
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] bsr_pins,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSR_LEN-1:0] bsr_hold
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_active;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_sel_e         dr_sel;
    logic            tdo_src;
    logic            in_shift;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck       (tck),
        .rst_n     (rst_n),
        .tdi       (tdi),
        .state     (state),
        .ir_active (ir_active),
        .ir_lsb    (ir_lsb)
    );

    assign dr_sel = dr_decode(ir_active);

    tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .tdi      (tdi),
        .state    (state),
        .dr_sel   (dr_sel),
        .bsr_pins (bsr_pins),
        .dr_lsb   (dr_lsb),
        .bsr_hold (bsr_hold)
    );

    // Serial source: instruction path in Shift-IR, data path otherwise.
    always_comb begin
        in_shift = (state == ST_SH_IR) || (state == ST_SH_DR);
        tdo_src  = (state == ST_SH_IR) ? ir_lsb : dr_lsb;
    end

    // Falling-edge output stage for tdo and its enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= tdo_src;
            tdo_en <= in_shift;
        end
    end

    AST_TDO_EN_IN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR)); // R10

endmodule

// File: tb/tb_tap_port.sv
`timescale 1ns/1ps
module tb_tap_port;

    localparam int          L      = 6;
    localparam logic [31:0] IDV    = 32'hA5C3_0F96;
    localparam logic [31:0] ID_EXP = 32'hA5C3_0F97;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [L-1:0] pins = '0;
    logic         tdo, tdo_en;
    logic [L-1:0] hold;

    int total = 0, bad = 0, r9_bad = 0;
    logic [63:0] got;
    logic [2:0]  cap;

    tap_port #(.BSR_LEN(L), .ID_VALUE(IDV)) dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .bsr_pins(pins),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_hold(hold)
    );

    always #2.5 tck = ~tck;

    // Row: {tms, tdi, expected tdo_en, expected tdo (checked when enabled)}.
    localparam logic [3:0] TBL [20] = '{
        4'b0000, 4'b1000, 4'b0000, 4'b0011, 4'b0011,
        4'b0011, 4'b0010, 4'b0011, 4'b1000, 4'b1000,
        4'b0000, 4'b1000, 4'b1000, 4'b0000, 4'b0011,
        4'b0110, 4'b0010, 4'b1000, 4'b1000, 4'b0000
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One tck period; also checks tdo does not move at the rising edge (R9).
    task automatic tick(input logic m, input logic d);
        logic pre_d, pre_e;
        tms = m; tdi = d;
        pre_d = tdo; pre_e = tdo_en;
        @(posedge tck); #1;
        if (tdo !== pre_d || tdo_en !== pre_e) r9_bad++;
        @(negedge tck); #1;
    endtask

    // From Idle: load an instruction; returns the captured IR bits.
    task automatic load_ir(input logic [2:0] code, output logic [2:0] c);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 3; i++) begin
            c[i] = tdo;
            tick(i == 2, code[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    // From Idle: scan n data bits through the selected register.
    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        #500000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge tck); #1;
        rst_n = 1'b0;
        tick(1, 0); tick(1, 0); tick(1, 0);
        check("R1 tdo_en in reset", {63'd0, tdo_en}, 64'd0);
        rst_n = 1'b1;

        // Vector table: IDCODE bits, IR capture, reload of IDCODE (R4 R8 R10).
        for (int i = 0; i < 20; i++) begin
            tick(TBL[i][3], TBL[i][2]);
            check($sformatf("R10 table row %0d tdo_en", i), {63'd0, tdo_en}, {63'd0, TBL[i][1]});
            if (TBL[i][1])
                check($sformatf("R4/R8 table row %0d tdo", i), {63'd0, tdo}, {63'd0, TBL[i][0]});
        end

        // Full ID word after reset.
        scan_dr(32, 64'h0, got);
        check("R1/R4 IDCODE word after reset", got, {32'd0, ID_EXP});

        // Instruction capture pattern and bypass.
        load_ir(3'b111, cap);
        check("R7 IR capture pattern", {61'd0, cap}, 64'd1);
        scan_dr(8, 64'hB2, got);
        check("R5 bypass one-bit delay", got, 64'h64);

        // Unused codes.
        for (int k = 0; k < 3; k++) begin
            logic [2:0] code;
            code = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
            load_ir(code, cap);
            scan_dr(8, 64'h5D, got);
            check($sformatf("R6 unused code %0b acts as bypass", code), got, 64'hBA);
        end

        // SAMPLE/PRELOAD: capture pins, update hold.
        pins = 6'h2D;
        load_ir(3'b100, cap);
        scan_dr(L, 64'h13, got);
        check("R11 sample/preload capture", got, 64'h2D);
        check("R12 hold after update", {58'd0, hold}, 64'h13);
        check("R8 shifted-in value lands MSB-in", {58'd0, hold}, 64'h13);

        // Update-DR under bypass leaves hold alone.
        load_ir(3'b111, cap);
        scan_dr(8, 64'hFF, got);
        check("R12 hold unchanged under bypass", {58'd0, hold}, 64'h13);

        // EXTEST and SAMPLE-Z also select the boundary register.
        pins = 6'h1A;
        load_ir(3'b000, cap);
        scan_dr(L, 64'h21, got);
        check("R11 extest capture", got, 64'h1A);
        check("R12 extest update", {58'd0, hold}, 64'h21);
        pins = 6'h05;
        load_ir(3'b010, cap);
        scan_dr(L, 64'h3C, got);
        check("R11 sample-z capture", got, 64'h05);
        check("R12 sample-z update", {58'd0, hold}, 64'h3C);

        // Pause detour in the middle of an IDCODE shift.
        load_ir(3'b001, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        check("R3 first ID bit", {63'd0, tdo}, 64'd1);
        tick(0, 0);
        tick(1, 0);
        check("R3 exit1 tdo_en low", {63'd0, tdo_en}, 64'd0);
        tick(0, 0); tick(0, 0);
        check("R3 pause tdo_en low", {63'd0, tdo_en}, 64'd0);
        tick(1, 0); tick(0, 0);
        check("R3 resumed shift enabled", {63'd0, tdo_en}, 64'd1);
        check("R3 resumed at ID bit 2", {63'd0, tdo}, {63'd0, ID_EXP[2]});
        tick(0, 0);
        check("R3 next ID bit 3", {63'd0, tdo}, {63'd0, ID_EXP[3]});
        tick(1, 0); tick(1, 0); tick(0, 0);

        // Five tms-high edges from Shift-DR under bypass.
        load_ir(3'b111, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        check("R2 tdo_en low after tms reset", {63'd0, tdo_en}, 64'd0);
        tick(0, 0);
        scan_dr(32, 64'h0, got);
        check("R2 IDCODE active after tms reset", got, {32'd0, ID_EXP});

        // Reset in the middle of a bypass shift.
        load_ir(3'b111, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        rst_n = 1'b0;
        tick(0, 0);
        check("R1 tdo_en low after mid-shift reset", {63'd0, tdo_en}, 64'd0);
        rst_n = 1'b1;
        tick(0, 0);
        scan_dr(32, 64'h0, got);
        check("R1 IDCODE after mid-shift reset", got, {32'd0, ID_EXP});

        check("R9 no tdo change at rising edge", r9_bad, 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule